// File: doc/BRIEF.md
# Masked Scalar Float Add Lane

This block adds the lowest single-precision element of two vector operands and returns a full vector. The low element holds the sum, or a masked substitute for it. The bits above the low element are passed through from an operand that depends on the instruction form. Around an IEEE-754 binary32 adder it adds three things: a choice of where the rounding mode comes from, a one-bit writemask that either merges or zeroes the low element, and two pass-through rules, one for a destructive two-operand form and one for a non-destructive three-operand form.

An execution pipe presents both sources, the current destination contents and the control fields with `in_valid`. One clock later it receives `out_valid`, the assembled vector and a five-bit exception vector. Subnormal inputs and outputs are handled with full gradual underflow. NaN results are always the default quiet NaN. Flags are reported to the caller and never trap inside the block.

Top module: `scalar_fadd_lane`

## Requirements
- R1: The rounding mode is `static_rnd` when `static_rnd_en` and `b_is_reg` are both 1; in every other case it is `global_rnd`.
- R2: When `three_op`=1 and either `use_mask`=0 or `lane_mask`=1, result bits 31:0 are the rounded binary32 sum of `src_a[31:0]` and `src_b[31:0]`.
- R3: When `three_op`=1, `use_mask`=1, `lane_mask`=0 and `zero_mask`=0, result bits 31:0 equal `prior_dst[31:0]`.
- R4: When `three_op`=1, `use_mask`=1, `lane_mask`=0 and `zero_mask`=1, result bits 31:0 are zero.
- R5: When `three_op`=1, result bits 127:32 equal `src_a[127:32]`, and any result bits above 127 are zero.
- R6: When `three_op`=0, the sum is `prior_dst[31:0]` plus `src_b[31:0]`, all result bits above 31 equal `prior_dst`, and `src_a` and the mask controls have no effect.
- R7: The rounding encodings are 00 nearest-even, 01 toward negative infinity, 10 toward positive infinity and 11 toward zero, and results are rounded accordingly.
- R8: Any NaN operand, or infinities of opposite sign, give 0x7FC00000. The invalid flag (bit 0) is set for a signalling NaN operand (exponent all ones, top fraction bit 0, fraction nonzero) or for opposite infinities, and is not set for a quiet NaN operand.
- R9: Subnormal operands are added exactly with gradual underflow and no flush to zero. The denormal flag (bit 1) is set when either operand is subnormal.
- R10: An exact zero sum of operands with opposite signs is +0, except under toward-negative rounding, where it is -0. The sum of two zeros of the same sign keeps that sign.
- R11: A result that is too large to represent sets overflow (bit 2) and inexact (bit 4). The value is infinity, or the largest finite value where the rounding direction points toward zero. Any rounding error sets inexact. Underflow (bit 3) is set only when a result is both tiny and inexact.
- R12: When the low element is suppressed by the mask (R3, R4), all five flags are reported as zero.
- R13: `out_valid` follows `in_valid` one clock later. `result` and `exc_flags` change only on a cycle with `in_valid`=1. After reset, `out_valid`, `result` and `exc_flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| src_a | input | 128 | First source vector (three-operand form) |
| src_b | input | 128 | Second source vector; only bits 31:0 are used |
| prior_dst | input | 128 | Current destination contents |
| three_op | input | 1 | 1: three-operand form, 0: destructive two-operand form |
| use_mask | input | 1 | Writemask in use (three-operand form only) |
| lane_mask | input | 1 | Writemask bit for the low element |
| zero_mask | input | 1 | 1: zero a masked element, 0: merge it |
| static_rnd_en | input | 1 | Per-operation rounding override requested |
| static_rnd | input | 2 | Per-operation rounding mode |
| global_rnd | input | 2 | Rounding mode from the global control register |
| b_is_reg | input | 1 | Second source came from a register |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Assembled result vector |
| exc_flags | output | 5 | {inexact, underflow, overflow, denormal, invalid} |

## Verification
Each wrong internal decision shows up in the very next `out_valid` cycle, because there is no state that outlives one operation. A wrong rounding-mode source or a wrong rounding rule moves the low element by one unit in the last place. The bench therefore uses halfway and sticky cases that give a different answer under each of the four modes. A wrong pass-through choice puts the wrong fill pattern in bits above 31, and a wrong mask decision shows up as a changed low element or as flags that should have been cleared. Special-value and subnormal paths are checked against exact bit patterns, including the sign of zero.

// File: rtl/fadd_lane_pkg.sv
package fadd_lane_pkg;

   typedef enum logic [1:0] {
      RND_NEAREST = 2'b00,
      RND_DOWN    = 2'b01,
      RND_UP      = 2'b10,
      RND_ZERO    = 2'b11
   } rnd_mode_e;

   localparam int FLG_INV = 0;
   localparam int FLG_DEN = 1;
   localparam int FLG_OVF = 2;
   localparam int FLG_UNF = 3;
   localparam int FLG_INX = 4;
   localparam int FLG_N   = 5;

endpackage

// File: rtl/fadd_rm_sel.sv
module fadd_rm_sel
   import fadd_lane_pkg::*;
(
   input  logic       static_en,
   input  logic       b_is_reg,
   input  logic [1:0] static_rm,
   input  logic [1:0] global_rm,
   output rnd_mode_e  rm
);
   // R1: per-operation override only for register sources
   assign rm = rnd_mode_e'((static_en && b_is_reg) ? static_rm : global_rm);
endmodule

// File: rtl/fadd_operand_class.sv
module fadd_operand_class #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] op,
   output logic                  sgn,
   output logic [EXP_W+1:0]      eff_exp,
   output logic [FRAC_W:0]       mant,
   output logic                  is_inf,
   output logic                  is_nan,
   output logic                  is_snan,
   output logic                  is_sub
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac;
   logic exp_zero, exp_ones, frac_zero;

   assign exp_f     = op[EXP_W+FRAC_W-1:FRAC_W];
   assign frac      = op[FRAC_W-1:0];
   assign exp_zero  = (exp_f == '0);
   assign exp_ones  = &exp_f;
   assign frac_zero = (frac == '0);

   assign sgn     = op[EXP_W+FRAC_W];
   assign is_inf  = exp_ones && frac_zero;
   assign is_nan  = exp_ones && !frac_zero;
   assign is_snan = is_nan && !frac[FRAC_W-1];
   assign is_sub  = exp_zero && !frac_zero;
   // subnormals and zero share the minimum normal exponent
   assign eff_exp = exp_zero ? (EXP_W+2)'(1) : {2'b00, exp_f};
   assign mant    = {!exp_zero, frac};
endmodule

// File: rtl/fadd_core.sv
module fadd_core
   import fadd_lane_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] op_a,
   input  logic [EXP_W+FRAC_W:0] op_b,
   input  rnd_mode_e             rm,
   output logic [EXP_W+FRAC_W:0] sum,
   output logic [FLG_N-1:0]      flags
);
   localparam int EW = 1 + EXP_W + FRAC_W;
   localparam int MW = FRAC_W + 1;
   localparam int XW = MW + 3;
   localparam int DW = EXP_W + 2;
   localparam int SW = $clog2(XW + 1);
   localparam logic [EXP_W-1:0] EXP_MAX = '1;
   localparam logic [EW-1:0] QNAN = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

   logic [1:0]         c_sgn, c_inf, c_nan, c_snan, c_sub;
   logic [1:0][DW-1:0] c_exp;
   logic [1:0][MW-1:0] c_man;

   for (genvar gi = 0; gi < 2; gi++) begin : g_cls
      fadd_operand_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .op      ((gi == 0) ? op_a : op_b),
         .sgn     (c_sgn[gi]),
         .eff_exp (c_exp[gi]),
         .mant    (c_man[gi]),
         .is_inf  (c_inf[gi]),
         .is_nan  (c_nan[gi]),
         .is_snan (c_snan[gi]),
         .is_sub  (c_sub[gi])
      );
   end

   function automatic logic [SW-1:0] lead_zeros(input logic [XW-1:0] v);
      lead_zeros = SW'(XW);
      for (int i = 0; i < XW; i++)
         if (v[i]) lead_zeros = SW'(XW - 1 - i);
   endfunction

   logic          b_big, eff_sub, big_s, tiny, grd, rst, inexact, up, ovf, to_inf;
   logic          spec_nan, spec_inv, zero_s;
   logic [DW-1:0] big_e, sml_e, d_full, lim, e_n, e_f;
   logic [MW-1:0] big_m, sml_m, mant, mf;
   logic [MW:0]   mr;
   logic [XW-1:0] a_ext, b_ext, al, shifted, norm;
   logic [XW:0]   raw;
   logic [SW-1:0] sh_amt, lz, shl;
   logic [EXP_W-1:0] exp_field;
   logic [EW-1:0] fin;

   assign b_big   = {c_exp[1], c_man[1]} > {c_exp[0], c_man[0]};
   assign eff_sub = c_sgn[0] ^ c_sgn[1];

   always_comb begin
      big_s = b_big ? c_sgn[1] : c_sgn[0];
      big_e = b_big ? c_exp[1] : c_exp[0];
      sml_e = b_big ? c_exp[0] : c_exp[1];
      big_m = b_big ? c_man[1] : c_man[0];
      sml_m = b_big ? c_man[0] : c_man[1];
      d_full = big_e - sml_e;
      a_ext = {big_m, 3'b000};
      b_ext = {sml_m, 3'b000};
      sh_amt = '0;
      shifted = '0;
      // alignment with sticky collection into bit 0
      if (d_full >= DW'(XW)) begin
         al = {{(XW-1){1'b0}}, |b_ext};
      end else begin
         sh_amt  = d_full[SW-1:0];
         shifted = b_ext >> sh_amt;
         al = shifted | {{(XW-1){1'b0}}, |(b_ext & ~({XW{1'b1}} << sh_amt))};
      end
      raw = eff_sub ? ({1'b0, a_ext} - {1'b0, al}) : ({1'b0, a_ext} + {1'b0, al});

      // normalisation, limited so the exponent never drops below 1
      lz  = lead_zeros(raw[XW-1:0]);
      lim = big_e - DW'(1);
      shl = '0;
      if (raw[XW]) begin
         norm = raw[XW:1] | {{(XW-1){1'b0}}, raw[0]};
         e_n  = big_e + DW'(1);
      end else begin
         shl  = (DW'(lz) > lim) ? lim[SW-1:0] : lz;
         norm = raw[XW-1:0] << shl;
         e_n  = big_e - DW'(shl);
      end
      tiny    = !norm[XW-1];
      mant    = norm[XW-1:3];
      grd     = norm[2];
      rst     = |norm[1:0];
      inexact = grd | rst;

      case (rm)
         RND_NEAREST: up = grd & (rst | mant[0]);
         RND_DOWN:    up = big_s & inexact;
         RND_UP:      up = !big_s & inexact;
         default:     up = 1'b0;
      endcase
      mr = {1'b0, mant} + (MW+1)'(up);
      if (mr[MW]) begin
         mf  = mr[MW:1];
         e_f = e_n + DW'(1);
      end else begin
         mf  = mr[MW-1:0];
         e_f = e_n;
      end
      exp_field = mf[MW-1] ? e_f[EXP_W-1:0] : '0;
      ovf    = mf[MW-1] && (e_f >= DW'(EXP_MAX));
      to_inf = (rm == RND_NEAREST) || (rm == RND_DOWN && big_s) || (rm == RND_UP && !big_s);

      if (ovf)
         fin = to_inf ? {big_s, EXP_MAX, {FRAC_W{1'b0}}}
                      : {big_s, EXP_MAX - EXP_W'(1), {FRAC_W{1'b1}}};
      else
         fin = {big_s, exp_field, mf[FRAC_W-1:0]};

      zero_s   = eff_sub ? (rm == RND_DOWN) : c_sgn[0];
      spec_nan = (|c_nan) || (&c_inf && eff_sub);
      spec_inv = (|c_snan) || (&c_inf && eff_sub);

      flags = '0;
      flags[FLG_DEN] = |c_sub;
      if (spec_nan) begin
         sum = QNAN;
         flags[FLG_INV] = spec_inv;
      end else if (|c_inf) begin
         sum = {c_inf[0] ? c_sgn[0] : c_sgn[1], EXP_MAX, {FRAC_W{1'b0}}};
      end else if (raw == '0) begin
         sum = {zero_s, {(EW-1){1'b0}}};
      end else begin
         sum = fin;
         flags[FLG_OVF] = ovf;
         flags[FLG_UNF] = tiny & inexact;
         flags[FLG_INX] = inexact | ovf;
      end
   end
endmodule

// File: rtl/fadd_lane_merge.sv
module fadd_lane_merge
   import fadd_lane_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int KEEP_W = 128,
   parameter int ELEM_W = 32
) (
   input  logic              three_op,
   input  logic              use_mask,
   input  logic              lane_mask,
   input  logic              zero_mask,
   input  logic [VEC_W-1:0]  src_a,
   input  logic [VEC_W-1:0]  prior,
   input  logic [ELEM_W-1:0] sum,
   input  logic [FLG_N-1:0]  flags_in,
   output logic [VEC_W-1:0]  merged,
   output logic [FLG_N-1:0]  flags_out
);
   logic lane_on;
   logic unused_src_lo;

   assign unused_src_lo = ^src_a[ELEM_W-1:0];
   assign lane_on = !(three_op && use_mask) || lane_mask;

   // R3 R4: merge or zero the suppressed element
   assign merged[ELEM_W-1:0] = lane_on ? sum : (zero_mask ? '0 : prior[ELEM_W-1:0]);
   assign flags_out = lane_on ? flags_in : '0;
   assign merged[KEEP_W-1:ELEM_W] = three_op ? src_a[KEEP_W-1:ELEM_W] : prior[KEEP_W-1:ELEM_W];

   if (VEC_W > KEEP_W) begin : g_wide
      assign merged[VEC_W-1:KEEP_W] = three_op ? '0 : prior[VEC_W-1:KEEP_W];
   end
endmodule

// File: rtl/scalar_fadd_lane.sv
module scalar_fadd_lane
   import fadd_lane_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int KEEP_W = 128,
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [VEC_W-1:0]  src_a,
   input  logic [VEC_W-1:0]  src_b,
   input  logic [VEC_W-1:0]  prior_dst,
   input  logic              three_op,
   input  logic              use_mask,
   input  logic              lane_mask,
   input  logic              zero_mask,
   input  logic              static_rnd_en,
   input  logic [1:0]        static_rnd,
   input  logic [1:0]        global_rnd,
   input  logic              b_is_reg,
   output logic              out_valid,
   output logic [VEC_W-1:0]  result,
   output logic [FLG_N-1:0]  exc_flags
);
   localparam int ELEM_W = 1 + EXP_W + FRAC_W;

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_fmt
      $error("scalar_fadd_lane: exponent and fraction need at least 2 bits");
   end
   if (VEC_W % ELEM_W != 0) begin : g_bad_vec
      $error("scalar_fadd_lane: VEC_W must be a multiple of the element width");
   end
   if (KEEP_W > VEC_W || KEEP_W <= ELEM_W) begin : g_bad_keep
      $error("scalar_fadd_lane: KEEP_W must lie above one element and within VEC_W");
   end

   rnd_mode_e          rm;
   logic [ELEM_W-1:0]  addend_a, sum;
   logic [FLG_N-1:0]   core_flags, lane_flags;
   logic [VEC_W-1:0]   merged;
   logic               unused_b_hi;

   assign unused_b_hi = ^src_b[VEC_W-1:ELEM_W];
   // R6: destructive form reads its first addend from the destination
   assign addend_a = three_op ? src_a[ELEM_W-1:0] : prior_dst[ELEM_W-1:0];

   fadd_rm_sel u_rm (
      .static_en (static_rnd_en),
      .b_is_reg  (b_is_reg),
      .static_rm (static_rnd),
      .global_rm (global_rnd),
      .rm        (rm)
   );

   fadd_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
      .op_a  (addend_a),
      .op_b  (src_b[ELEM_W-1:0]),
      .rm    (rm),
      .sum   (sum),
      .flags (core_flags)
   );

   fadd_lane_merge #(.VEC_W(VEC_W), .KEEP_W(KEEP_W), .ELEM_W(ELEM_W)) u_merge (
      .three_op  (three_op),
      .use_mask  (use_mask),
      .lane_mask (lane_mask),
      .zero_mask (zero_mask),
      .src_a     (src_a),
      .prior     (prior_dst),
      .sum       (sum),
      .flags_in  (core_flags),
      .merged    (merged),
      .flags_out (lane_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         exc_flags <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= merged;
            exc_flags <= lane_flags;
         end
      end
   end

   p_valid_follow_r13: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(exc_flags)));
   p_merge_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && three_op && use_mask && !lane_mask && !zero_mask)
      |=> result[ELEM_W-1:0] == $past(prior_dst[ELEM_W-1:0]));
   p_zero_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && three_op && use_mask && !lane_mask && zero_mask)
      |=> result[ELEM_W-1:0] == '0);
   p_upper_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && three_op)
      |=> result[KEEP_W-1:ELEM_W] == $past(src_a[KEEP_W-1:ELEM_W]));
   p_legacy_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !three_op)
      |=> result[VEC_W-1:ELEM_W] == $past(prior_dst[VEC_W-1:ELEM_W]));
   p_quiet_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && three_op && use_mask && !lane_mask) |=> exc_flags == '0);
   p_ovf_inexact_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (!exc_flags[FLG_OVF] || exc_flags[FLG_INX]));
   p_unf_inexact_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (!exc_flags[FLG_UNF] || exc_flags[FLG_INX]));
endmodule

// File: tb/sim_scalar_fadd_lane.sv
`timescale 1ns/1ps
module sim_scalar_fadd_lane;
   localparam logic [95:0] UA = 96'hA1A2A3A4_B1B2B3B4_C1C2C3C4;
   localparam logic [95:0] UP = 96'h5152_5354_6162_6364_7172_7374;
   localparam logic [95:0] UB = 96'hDEAD_0000_BEEF_1111_2222_3333;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] src_a = '0, src_b = '0, prior_dst = '0;
   logic         three_op = 1'b1, use_mask = 1'b0, lane_mask = 1'b0, zero_mask = 1'b0;
   logic         static_rnd_en = 1'b0, b_is_reg = 1'b0;
   logic [1:0]   static_rnd = 2'b00, global_rnd = 2'b00;
   logic         out_valid;
   logic [127:0] result;
   logic [4:0]   exc_flags;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   scalar_fadd_lane u0 (
      .clk, .rst_n, .in_valid, .src_a, .src_b, .prior_dst,
      .three_op, .use_mask, .lane_mask, .zero_mask,
      .static_rnd_en, .static_rnd, .global_rnd, .b_is_reg,
      .out_valid, .result, .exc_flags
   );

   task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // one transaction: drive on a falling edge, sample on the next one
   task automatic run(input logic t3, um, lm, zm, sen, input logic [1:0] srm, grm,
                      input logic breg, input logic [31:0] a, b, p);
      @(negedge clk);
      three_op = t3; use_mask = um; lane_mask = lm; zero_mask = zm;
      static_rnd_en = sen; static_rnd = srm; global_rnd = grm; b_is_reg = breg;
      src_a = {UA, a}; src_b = {UB, b}; prior_dst = {UP, p};
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_out(input string tag, input logic [31:0] lo, input logic [4:0] fl,
                             input logic t3);
      chk({tag, " result"}, result, {t3 ? UA : UP, lo});
      chk({tag, " flags"}, {123'd0, exc_flags}, {123'd0, fl});
      chk({tag, " valid"}, {127'd0, out_valid}, 128'd1);
   endtask

   // simple three-operand add under a global mode
   task automatic add3(input logic [1:0] grm, input logic [31:0] a, b);
      run(1, 0, 0, 0, 0, 2'b00, grm, 1, a, b, 32'h0BAD_F00D);
   endtask

   task automatic t_reset;
      chk("R13 reset valid", {127'd0, out_valid}, 128'd0);
      chk("R13 reset result", result, 128'd0);
      chk("R13 reset flags", {123'd0, exc_flags}, 128'd0);
   endtask

   task automatic t_basic;
      add3(2'b00, 32'h3F800000, 32'h40000000);
      expect_out("R2 R5 one plus two", 32'h40400000, 5'h00, 1);
      add3(2'b00, 32'h3F800000, 32'h33800000);
      expect_out("R11 inexact tie to even", 32'h3F800000, 5'h10, 1);
   endtask

   task automatic t_round;
      add3(2'b00, 32'h3F800001, 32'h33800000); expect_out("R7 nearest pos", 32'h3F800002, 5'h10, 1);
      add3(2'b11, 32'h3F800001, 32'h33800000); expect_out("R7 zero pos",    32'h3F800001, 5'h10, 1);
      add3(2'b10, 32'h3F800001, 32'h33800000); expect_out("R7 up pos",      32'h3F800002, 5'h10, 1);
      add3(2'b01, 32'h3F800001, 32'h33800000); expect_out("R7 down pos",    32'h3F800001, 5'h10, 1);
      add3(2'b00, 32'hBF800001, 32'hB3800000); expect_out("R7 nearest neg", 32'hBF800002, 5'h10, 1);
      add3(2'b11, 32'hBF800001, 32'hB3800000); expect_out("R7 zero neg",    32'hBF800001, 5'h10, 1);
      add3(2'b10, 32'hBF800001, 32'hB3800000); expect_out("R7 up neg",      32'hBF800001, 5'h10, 1);
      add3(2'b01, 32'hBF800001, 32'hB3800000); expect_out("R7 down neg",    32'hBF800002, 5'h10, 1);
   endtask

   task automatic t_rm_source;
      run(1, 0, 0, 0, 1, 2'b10, 2'b11, 1, 32'h3F800001, 32'h33800000, 32'h0);
      expect_out("R1 static used", 32'h3F800002, 5'h10, 1);
      run(1, 0, 0, 0, 1, 2'b10, 2'b11, 0, 32'h3F800001, 32'h33800000, 32'h0);
      expect_out("R1 memory source uses global", 32'h3F800001, 5'h10, 1);
      run(1, 0, 0, 0, 0, 2'b10, 2'b11, 1, 32'h3F800001, 32'h33800000, 32'h0);
      expect_out("R1 override off uses global", 32'h3F800001, 5'h10, 1);
   endtask

   task automatic t_mask;
      run(1, 1, 0, 0, 0, 2'b00, 2'b00, 1, 32'h3F800000, 32'h33800000, 32'h12345678);
      expect_out("R3 R12 merge keeps prior", 32'h12345678, 5'h00, 1);
      run(1, 1, 0, 1, 0, 2'b00, 2'b00, 1, 32'h3F800000, 32'h33800000, 32'h12345678);
      expect_out("R4 R12 zero masking", 32'h00000000, 5'h00, 1);
      run(1, 1, 1, 1, 0, 2'b00, 2'b00, 1, 32'h3F800000, 32'h40000000, 32'h12345678);
      expect_out("R2 mask bit set", 32'h40400000, 5'h00, 1);
      run(1, 0, 0, 1, 0, 2'b00, 2'b00, 1, 32'h3F800000, 32'h40000000, 32'h12345678);
      expect_out("R2 no mask in use", 32'h40400000, 5'h00, 1);
   endtask

   task automatic t_legacy;
      run(0, 0, 0, 0, 0, 2'b00, 2'b00, 1, 32'hDEADBEEF, 32'h3F800000, 32'h40000000);
      expect_out("R6 legacy adds destination", 32'h40400000, 5'h00, 0);
      run(0, 1, 0, 1, 0, 2'b00, 2'b00, 1, 32'h7F800001, 32'h3F800000, 32'h40000000);
      expect_out("R6 legacy ignores mask and src_a", 32'h40400000, 5'h00, 0);
   endtask

   task automatic t_special;
      add3(2'b00, 32'h7F800000, 32'hFF800000); expect_out("R8 inf minus inf", 32'h7FC00000, 5'h01, 1);
      add3(2'b00, 32'h7FC00001, 32'h3F800000); expect_out("R8 quiet nan",     32'h7FC00000, 5'h00, 1);
      add3(2'b00, 32'h3F800000, 32'hFF800001); expect_out("R8 signalling nan", 32'h7FC00000, 5'h01, 1);
      add3(2'b00, 32'hFF800000, 32'h3F800000); expect_out("R8 inf plus finite", 32'hFF800000, 5'h00, 1);
   endtask

   task automatic t_subnormal;
      add3(2'b00, 32'h00000001, 32'h00000001); expect_out("R9 subnormal sum", 32'h00000002, 5'h02, 1);
      add3(2'b00, 32'h007FFFFF, 32'h00000001); expect_out("R9 subnormal to normal", 32'h00800000, 5'h02, 1);
   endtask

   task automatic t_zero_sign;
      add3(2'b00, 32'h3F800000, 32'hBF800000); expect_out("R10 cancel nearest", 32'h00000000, 5'h00, 1);
      add3(2'b01, 32'h3F800000, 32'hBF800000); expect_out("R10 cancel down",    32'h80000000, 5'h00, 1);
      add3(2'b00, 32'h80000000, 32'h80000000); expect_out("R10 neg zeros",      32'h80000000, 5'h00, 1);
   endtask

   task automatic t_overflow;
      add3(2'b00, 32'h7F7FFFFF, 32'h7F7FFFFF); expect_out("R11 ovf nearest", 32'h7F800000, 5'h14, 1);
      add3(2'b11, 32'h7F7FFFFF, 32'h7F7FFFFF); expect_out("R11 ovf zero",    32'h7F7FFFFF, 5'h14, 1);
      add3(2'b10, 32'hFF7FFFFF, 32'hFF7FFFFF); expect_out("R11 ovf up neg",  32'hFF7FFFFF, 5'h14, 1);
      add3(2'b01, 32'hFF7FFFFF, 32'hFF7FFFFF); expect_out("R11 ovf down neg", 32'hFF800000, 5'h14, 1);
   endtask

   task automatic t_idle;
      add3(2'b00, 32'h3F800000, 32'h40000000);
      @(negedge clk);
      src_a = '1; src_b = '1; prior_dst = '1;
      @(negedge clk);
      chk("R13 idle valid low", {127'd0, out_valid}, 128'd0);
      chk("R13 idle result held", result, {UA, 32'h40400000});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_basic();
      t_round();
      t_rm_source();
      t_mask();
      t_legacy();
      t_special();
      t_subnormal();
      t_zero_sign();
      t_overflow();
      t_idle();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R13 got=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule